// File: doc/BRIEF.md
# Store Queue Commit and Writeback Tracker

This block tracks the stores of one thread in a circular queue with three pointers. New stores enter at the tail in program order. A commit bound marks older stores as committed and eligible to write back. A writeback pointer offers committed stores to memory one at a time and in order. A store leaves the queue at the head only after memory reports its write complete. A squash bound discards speculative stores that are younger than the bound and pulls the tail back over them.

Sequence numbers are plain unsigned values that grow with program age, so a smaller value is older. The memory side sees a request with the slot index and the sequence number. It accepts or refuses the request in the same cycle, and it reports completion later by slot index, in any order. One slot stays empty as a sentinel, so `DEPTH` slots hold at most `DEPTH-1` stores. `DEPTH` must be a power of two, at least 4.

Top module: `sq_track`

## Requirements
- R1: After reset, the count is 0 and full, the pending count, the pending flag, the request, the blocked flag and the head sequence output are all 0.
- R2: A store that is allocated goes into the tail slot and raises the count by one. The head sequence output shows the oldest held store, or 0 when the head slot is empty.
- R3: Full is high when the count equals DEPTH-1. An allocation while full is ignored.
- R4: A commit marks every held, uncommitted store whose sequence number is at most the bound. Each such store adds one to the pending count on the next cycle.
- R5: A request is raised only for the slot at the writeback pointer, when that slot holds a committed, not-completed store and the block is not blocked. Stores are offered in allocation order, carrying their slot index and sequence number.
- R6: A request that memory refuses sets the blocked flag. The flag holds the request low and keeps the writeback pointer in place until a retry pulse clears it.
- R7: Each accepted request lowers the pending count by one. The pending flag is high exactly when that count is nonzero.
- R8: A store is freed only after its completion is reported. Completions may arrive in any order. The head moves over completed stores at one store per cycle.
- R9: A squash removes every uncommitted store whose sequence number is above the bound. The tail moves back, so the next allocation reuses the first freed slot.
- R10: A committed store is never removed by a squash, even when its sequence number is above the bound.
- R11: When a squash and an allocation fall in the same cycle, the squash takes effect and the allocation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| commit_valid | input | 1 | Apply the commit bound |
| commit_seq | input | SEQ_W | Youngest sequence number to commit |
| squash_valid | input | 1 | Apply the squash bound |
| squash_seq | input | SEQ_W | Stores above this number are squashed |
| wb_req | output | 1 | Writeback request to memory |
| wb_idx | output | log2(DEPTH) | Slot index of the requested store |
| wb_seq | output | SEQ_W | Sequence number of the requested store |
| mem_accept | input | 1 | Memory takes the request this cycle |
| mem_retry | input | 1 | Memory can take a refused request again |
| cmp_valid | input | 1 | Writeback completion report |
| cmp_idx | input | log2(DEPTH) | Slot index being completed |
| sq_count | output | log2(DEPTH) | Number of held stores |
| sq_full | output | 1 | Queue holds DEPTH-1 stores |
| wb_pending_cnt | output | log2(DEPTH) | Committed stores not yet sent |
| wb_pending | output | 1 | Pending count is nonzero |
| head_seq | output | SEQ_W | Sequence number at the head, 0 if empty |
| st_blocked | output | 1 | A refused request awaits retry |

## Verification
A wrong pointer or flag shows up at the ports within one or two cycles. A bad writeback pointer sends a store out of order or with the wrong sequence number on the next accepted request. A bad tail shows as a wrong count, or as a reused slot index that appears when a later store is sent. A lost committed or completed flag stalls the pending count or the head, and the head sequence output then differs from the expected value in the cycle after the completion. The scoreboard predicts every sent sequence number from the commits it issued, so any reordering or extra send is caught at the request itself.

// File: rtl/sq_track_pkg.sv
package sq_track_pkg;
   typedef struct packed {
      logic valid;
      logic committed;
      logic done;
   } sq_flags_t;
endpackage

// File: rtl/sq_track_popcnt.sv
module sq_track_popcnt #(
   parameter int N = 8,
   parameter int W = 4
) (
   input  logic [N-1:0] bits_i,
   output logic [W-1:0] cnt_o
);
   generate
      if (N == 1) begin : g_single
         assign cnt_o = W'(bits_i[0]);
      end else begin : g_loop
         always_comb begin
            cnt_o = '0;
            for (int k = 0; k < N; k++) cnt_o = cnt_o + W'(bits_i[k]);
         end
      end
   endgenerate
endmodule

// File: rtl/sq_track_slots.sv
module sq_track_slots
   import sq_track_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          alloc_en,
   input  logic [IDX_W-1:0]              alloc_idx,
   input  logic [SEQ_W-1:0]              alloc_seq,
   input  logic                          commit_valid,
   input  logic [SEQ_W-1:0]              commit_seq,
   input  logic                          squash_valid,
   input  logic [SEQ_W-1:0]              squash_seq,
   input  logic                          free_en,
   input  logic [IDX_W-1:0]              free_idx,
   input  logic                          cmp_valid,
   input  logic [IDX_W-1:0]              cmp_idx,
   output sq_flags_t [DEPTH-1:0]         flags,
   output logic [DEPTH-1:0][SEQ_W-1:0]   seqs,
   output logic [DEPTH-1:0]              hit,
   output logic [DEPTH-1:0]              kill
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic             v_q, c_q, d_q;
      logic [SEQ_W-1:0] s_q;

      assign hit[i]  = commit_valid && v_q && !c_q && (s_q <= commit_seq);
      assign kill[i] = squash_valid && v_q && !c_q && !hit[i] && (s_q > squash_seq);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            c_q <= 1'b0;
            d_q <= 1'b0;
            s_q <= '0;
         end else if (kill[i]) begin
            v_q <= 1'b0;
            c_q <= 1'b0;
            d_q <= 1'b0;
         end else if (free_en && free_idx == IDX_W'(i)) begin
            v_q <= 1'b0;
            c_q <= 1'b0;
            d_q <= 1'b0;
         end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
            v_q <= 1'b1;
            c_q <= 1'b0;
            d_q <= 1'b0;
            s_q <= alloc_seq;
         end else begin
            if (hit[i]) c_q <= 1'b1;
            if (cmp_valid && cmp_idx == IDX_W'(i) && v_q && c_q) d_q <= 1'b1;
         end
      end

      assign flags[i] = {v_q, c_q, d_q};
      assign seqs[i]  = s_q;
   end
endmodule

// File: rtl/sq_track.sv
module sq_track
   import sq_track_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [SEQ_W-1:0] alloc_seq,
   input  logic             commit_valid,
   input  logic [SEQ_W-1:0] commit_seq,
   input  logic             squash_valid,
   input  logic [SEQ_W-1:0] squash_seq,
   output logic             wb_req,
   output logic [IDX_W-1:0] wb_idx,
   output logic [SEQ_W-1:0] wb_seq,
   input  logic             mem_accept,
   input  logic             mem_retry,
   input  logic             cmp_valid,
   input  logic [IDX_W-1:0] cmp_idx,
   output logic [IDX_W-1:0] sq_count,
   output logic             sq_full,
   output logic [IDX_W-1:0] wb_pending_cnt,
   output logic             wb_pending,
   output logic [SEQ_W-1:0] head_seq,
   output logic             st_blocked
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sq_track: DEPTH must be a power of two and at least 4");
      end
      if (SEQ_W < 2) begin : g_bad_seq
         $error("sq_track: SEQ_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0]            head_q, tail_q, wbp_q, pend_q;
   logic                        blk_q;
   sq_flags_t [DEPTH-1:0]       flags;
   logic [DEPTH-1:0][SEQ_W-1:0] seqs;
   logic [DEPTH-1:0]            hit, kill;
   logic [CNT_W-1:0]            hit_cnt, kill_cnt;
   logic                        alloc_en, free_en, send;

   sq_track_slots #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_slots (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_en     (alloc_en),
      .alloc_idx    (tail_q),
      .alloc_seq    (alloc_seq),
      .commit_valid (commit_valid),
      .commit_seq   (commit_seq),
      .squash_valid (squash_valid),
      .squash_seq   (squash_seq),
      .free_en      (free_en),
      .free_idx     (head_q),
      .cmp_valid    (cmp_valid),
      .cmp_idx      (cmp_idx),
      .flags        (flags),
      .seqs         (seqs),
      .hit          (hit),
      .kill         (kill)
   );

   sq_track_popcnt #(.N(DEPTH), .W(CNT_W)) u_hit_cnt  (.bits_i(hit),  .cnt_o(hit_cnt));
   sq_track_popcnt #(.N(DEPTH), .W(CNT_W)) u_kill_cnt (.bits_i(kill), .cnt_o(kill_cnt));

   assign sq_count       = tail_q - head_q;
   assign sq_full        = (sq_count == IDX_W'(DEPTH - 1));
   assign alloc_en       = alloc_valid && !sq_full && !squash_valid;
   assign free_en        = flags[head_q].valid && flags[head_q].done;
   assign wb_req         = flags[wbp_q].valid && flags[wbp_q].committed &&
                           !flags[wbp_q].done && !blk_q;
   assign send           = wb_req && mem_accept;
   assign wb_idx         = wbp_q;
   assign wb_seq         = seqs[wbp_q];
   assign wb_pending_cnt = pend_q;
   assign wb_pending     = (pend_q != '0);
   assign head_seq       = flags[head_q].valid ? seqs[head_q] : '0;
   assign st_blocked     = blk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         wbp_q  <= '0;
         pend_q <= '0;
         blk_q  <= 1'b0;
      end else begin
         if (squash_valid)  tail_q <= tail_q - kill_cnt[IDX_W-1:0];
         else if (alloc_en) tail_q <= tail_q + 1'b1;
         if (free_en)       head_q <= head_q + 1'b1;
         if (send)          wbp_q  <= wbp_q + 1'b1;
         pend_q <= pend_q + hit_cnt[IDX_W-1:0] - IDX_W'(send);
         if (wb_req && !mem_accept) blk_q <= 1'b1;
         else if (mem_retry)        blk_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sq_track_chk.sv
module sq_track_chk #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             commit_valid,
   input logic             squash_valid,
   input logic             wb_req,
   input logic             mem_accept,
   input logic [IDX_W-1:0] sq_count,
   input logic             sq_full,
   input logic [IDX_W-1:0] wb_pending_cnt,
   input logic             wb_pending,
   input logic [SEQ_W-1:0] head_seq,
   input logic             st_blocked
);
   assert_full_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sq_full && alloc_valid |=> sq_count <= $past(sq_count));

   assert_empty_head_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sq_count == '0 |-> head_seq == '0);

   assert_blocked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      st_blocked |-> !wb_req);

   assert_refusal_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !mem_accept |=> st_blocked);

   assert_req_has_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> wb_pending);

   assert_send_decrements_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && mem_accept && !commit_valid |=>
         wb_pending_cnt == $past(wb_pending_cnt) - IDX_W'(1));

   assert_squash_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> sq_count <= $past(sq_count));
endmodule

bind sq_track sq_track_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_valid    (alloc_valid),
   .commit_valid   (commit_valid),
   .squash_valid   (squash_valid),
   .wb_req         (wb_req),
   .mem_accept     (mem_accept),
   .sq_count       (sq_count),
   .sq_full        (sq_full),
   .wb_pending_cnt (wb_pending_cnt),
   .wb_pending     (wb_pending),
   .head_seq       (head_seq),
   .st_blocked     (st_blocked)
);

// File: tb/sq_track_test.sv
module sq_track_test;
   localparam int DEPTH = 8;
   localparam int SEQ_W = 16;
   localparam int IW    = 3;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             alloc_valid = 0, commit_valid = 0, squash_valid = 0;
   logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
   logic             mem_accept = 1, mem_retry = 0, cmp_valid = 0;
   logic [IW-1:0]    cmp_idx = '0;
   logic             wb_req, sq_full, wb_pending, st_blocked;
   logic [IW-1:0]    wb_idx, sq_count, wb_pending_cnt;
   logic [SEQ_W-1:0] wb_seq, head_seq;

   sq_track #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
      .commit_valid(commit_valid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .wb_req(wb_req), .wb_idx(wb_idx), .wb_seq(wb_seq),
      .mem_accept(mem_accept), .mem_retry(mem_retry),
      .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
      .sq_count(sq_count), .sq_full(sq_full),
      .wb_pending_cnt(wb_pending_cnt), .wb_pending(wb_pending),
      .head_seq(head_seq), .st_blocked(st_blocked)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit ended = 0;
   logic [SEQ_W-1:0] exp_q[$];
   logic [IW-1:0]    sent_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic next();
      @(negedge clk); #1;
      alloc_valid = 0; commit_valid = 0; squash_valid = 0;
      mem_retry = 0; cmp_valid = 0;
   endtask

   task automatic alloc(input logic [SEQ_W-1:0] s);
      alloc_valid = 1; alloc_seq = s; next();
   endtask

   task automatic commit(input logic [SEQ_W-1:0] b);
      commit_valid = 1; commit_seq = b; next();
   endtask

   task automatic squash(input logic [SEQ_W-1:0] b);
      squash_valid = 1; squash_seq = b; next();
   endtask

   task automatic complete(input logic [IW-1:0] i);
      cmp_valid = 1; cmp_idx = i; next();
   endtask

   // monitor: every accepted request is compared with the scoreboard (R5)
   initial forever begin
      @(negedge clk); #2;
      if (rst_n === 1'b1 && wb_req === 1'b1 && mem_accept === 1'b1) begin
         if (exp_q.size() == 0) chk("R5 unexpected send", 32'(wb_seq), 32'hFFFF_FFFF);
         else chk("R5 send order", 32'(wb_seq), 32'(exp_q.pop_front()));
         sent_q.push_back(wb_idx);
      end
   end

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_test();
   end

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      next();
      // R1 reset state
      chk("R1 count", 32'(sq_count), 0);
      chk("R1 full", 32'(sq_full), 0);
      chk("R1 pending", 32'(wb_pending_cnt), 0);
      chk("R1 pending flag", 32'(wb_pending), 0);
      chk("R1 req", 32'(wb_req), 0);
      chk("R1 blocked", 32'(st_blocked), 0);
      chk("R1 head seq", 32'(head_seq), 0);

      for (int s = 10; s <= 13; s++) alloc(SEQ_W'(s));
      chk("R2 count", 32'(sq_count), 4);
      chk("R2 head seq", 32'(head_seq), 10);
      chk("R5 no req uncommitted", 32'(wb_req), 0);

      // R4/R6: commit two, memory refuses
      mem_accept = 0;
      exp_q.push_back(10); exp_q.push_back(11);
      commit(11);
      chk("R4 pending", 32'(wb_pending_cnt), 2);
      chk("R7 pending flag", 32'(wb_pending), 1);
      chk("R5 req", 32'(wb_req), 1);
      chk("R5 req seq", 32'(wb_seq), 10);
      next();
      chk("R6 blocked", 32'(st_blocked), 1);
      chk("R6 req low", 32'(wb_req), 0);
      mem_accept = 1;
      next();
      chk("R6 held without retry", 32'(wb_req), 0);
      chk("R6 pending held", 32'(wb_pending_cnt), 2);
      mem_retry = 1;
      next();
      repeat (3) next();
      chk("R6 cleared", 32'(st_blocked), 0);
      chk("R7 pending zero", 32'(wb_pending_cnt), 0);
      chk("R7 flag low", 32'(wb_pending), 0);
      chk("R5 all sent", 32'(exp_q.size()), 0);

      // R8 out-of-order completion
      complete(1);
      next();
      chk("R8 not freed early count", 32'(sq_count), 4);
      chk("R8 not freed early head", 32'(head_seq), 10);
      complete(0);
      next();
      chk("R8 one step count", 32'(sq_count), 3);
      chk("R8 one step head", 32'(head_seq), 11);
      next();
      chk("R8 second step count", 32'(sq_count), 2);
      chk("R8 second step head", 32'(head_seq), 12);
      sent_q.delete();

      // R9/R11 squash with concurrent allocation
      alloc_valid = 1; alloc_seq = 14;
      squash(12);
      chk("R9 R11 count", 32'(sq_count), 1);
      chk("R9 head", 32'(head_seq), 12);

      // R10 committed store survives squash
      exp_q.push_back(12);
      commit(12);
      squash(5);
      chk("R10 count", 32'(sq_count), 1);
      chk("R10 head", 32'(head_seq), 12);

      exp_q.push_back(30);
      alloc(30);
      chk("R9 count after realloc", 32'(sq_count), 2);
      commit(30);
      repeat (2) next();
      chk("R9 sends", 32'(sent_q.size()), 2);
      if (sent_q.size() == 2) chk("R9 tail reused slot", 32'(sent_q[1]), 3);
      complete(2); complete(3);
      repeat (3) next();
      chk("R2 empty count", 32'(sq_count), 0);
      chk("R2 empty head seq", 32'(head_seq), 0);
      sent_q.delete();

      // R3 full
      for (int s = 20; s <= 26; s++) alloc(SEQ_W'(s));
      chk("R3 full", 32'(sq_full), 1);
      chk("R3 count", 32'(sq_count), 7);
      alloc(27);
      chk("R3 ignored alloc", 32'(sq_count), 7);
      for (int s = 20; s <= 26; s++) exp_q.push_back(SEQ_W'(s));
      commit(100);
      repeat (10) next();
      chk("R7 drained", 32'(wb_pending_cnt), 0);
      chk("R5 full drain", 32'(exp_q.size()), 0);
      while (sent_q.size() > 0) complete(sent_q.pop_front());
      repeat (10) next();
      chk("R8 all freed", 32'(sq_count), 0);
      chk("R3 not full", 32'(sq_full), 0);
      chk("R2 final head seq", 32'(head_seq), 0);
      finish_test();
   end
endmodule